// File: doc/BRIEF.md
# Instruction Fetch and Next-Address Unit

This unit owns the program counter of a single-cycle processor. The counter drives the instruction-memory address directly. The 32-bit word that the memory returns is passed straight on to the rest of the datapath, with no register in between. During the same cycle the unit works out where the following instruction lives.

Two candidates are formed every cycle. The first is the sequential address, which is the counter plus four. The second is the branch target: the sequential address plus the 16-bit immediate of the current instruction, sign-extended and scaled to a byte offset by appending two zero bits. The target is chosen only when the datapath's branch-select control and its register-equality flag are both high. The counter loads the chosen address on the common rising clock edge. All address arithmetic wraps around at the top of the address space.

A parameter chooses how the target adder is built. In one form the offset is added to the already-formed sequential address. In the other, four is folded into the offset first, so that the target sum runs in parallel with the sequential sum. Both forms give identical results.

Top module: `fetch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the counter loads `RESET_VEC` (default 0) on that edge, whatever the branch inputs are.
- R2: `fetch_addr` always equals the current counter value, and `instr` equals `fetch_word` in the same cycle, with no clock delay.
- R3: With `br_sel` low, the counter advances by exactly 4 at each edge, whatever `eq_flag` and `imm16` are.
- R4: With `br_sel` high and `eq_flag` low, the counter advances by exactly 4.
- R5: With `br_sel` and `eq_flag` both high, the next counter value is the current value + 4 + {sign-extended `imm16`, 2'b00}. Bit 15 of `imm16` is the sign bit.
- R6: A negative immediate (bit 15 set) moves the counter backwards. For example, `imm16` = 16'hFFFD gives a next value of counter + 4 − 12.
- R7: All address sums wrap modulo 2^ADDR_W, in both directions.
- R8: Bits [1:0] of `fetch_addr` are 0 in every cycle after reset.
- R9: The extreme offsets are exact. `imm16` = 16'h7FFF gives counter + 4 + 0x1FFFC, and `imm16` = 16'h8000 gives counter + 4 − 0x20000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| br_sel | input | 1 | Branch-select control from the decoder |
| eq_flag | input | 1 | High when the two compared registers are equal |
| imm16 | input | 16 | Immediate field of the current instruction |
| fetch_addr | output | ADDR_W (32) | Instruction-memory address; this is the counter |
| fetch_word | input | INSTR_W (32) | Word returned by the instruction memory |
| instr | output | INSTR_W (32) | Fetched instruction, passed to the datapath |

## Verification
Any fault in the counter or in the next-address logic shows up on `fetch_addr` one edge after the cycle that caused it. Every result can therefore be checked one cycle at a time against a reference address advanced by the bench. A wrong sign extension or a wrong scaling is visible only for particular immediates, so the stimulus covers both signs, both extremes and values that wrap. An error in the taken decision is visible only for the input combinations where exactly one of `br_sel` and `eq_flag` is high, so each of those combinations appears on its own.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned ALIGN_BITS = 2;

   typedef enum logic {
      NPC_SEQ = 1'b0,
      NPC_TGT = 1'b1
   } npc_sel_e;
endpackage

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg #(
   parameter int unsigned    ADDR_W    = 32,
   parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] pc_d,
   output logic [ADDR_W-1:0] pc_q
);
   always_ff @(posedge clk) begin
      if (rst) pc_q <= RESET_VEC;
      else     pc_q <= pc_d;
   end
endmodule

// File: rtl/fetch_next_addr.sv
module fetch_next_addr
   import fetch_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned IMM_W    = 16,
   parameter bit          PAR_TGT  = 1'b1
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [IMM_W-1:0]  imm,
   input  logic              take,
   output logic [ADDR_W-1:0] pc_next
);
   localparam int unsigned EXT_W = ADDR_W - IMM_W - ALIGN_BITS;

   logic [ADDR_W-1:0] byte_off;
   logic [ADDR_W-1:0] seq_addr;
   logic [ADDR_W-1:0] tgt_addr;
   npc_sel_e          sel;

   assign byte_off = {{EXT_W{imm[IMM_W-1]}}, imm, {ALIGN_BITS{1'b0}}};
   assign seq_addr = pc + ADDR_W'(WORD_BYTES);

   generate
      if (PAR_TGT) begin : g_par
         logic [ADDR_W-1:0] off_plus;
         assign off_plus = byte_off + ADDR_W'(WORD_BYTES);
         assign tgt_addr = pc + off_plus;
      end else begin : g_chain
         assign tgt_addr = seq_addr + byte_off;
      end
   endgenerate

   assign sel = take ? NPC_TGT : NPC_SEQ;

   always_comb begin
      unique case (sel)
         NPC_TGT: pc_next = tgt_addr;
         default: pc_next = seq_addr;
      endcase
   end
endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
   import fetch_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 32,
   parameter int unsigned       INSTR_W   = 32,
   parameter int unsigned       IMM_W     = 16,
   parameter logic [ADDR_W-1:0] RESET_VEC = '0,
   parameter bit                PAR_TGT   = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               br_sel,
   input  logic               eq_flag,
   input  logic [IMM_W-1:0]   imm16,
   output logic [ADDR_W-1:0]  fetch_addr,
   input  logic [INSTR_W-1:0] fetch_word,
   output logic [INSTR_W-1:0] instr
);
   initial begin
      if (ADDR_W < IMM_W + ALIGN_BITS)
         $error("fetch_unit: ADDR_W too narrow for scaled immediate");
      if (RESET_VEC[ALIGN_BITS-1:0] != '0)
         $error("fetch_unit: RESET_VEC must be word aligned");
   end

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] pc_d;
   logic              take;

   assign take = br_sel & eq_flag;

   fetch_next_addr #(
      .ADDR_W  (ADDR_W),
      .IMM_W   (IMM_W),
      .PAR_TGT (PAR_TGT)
   ) u_next (
      .pc      (pc_q),
      .imm     (imm16),
      .take    (take),
      .pc_next (pc_d)
   );

   fetch_pc_reg #(
      .ADDR_W    (ADDR_W),
      .RESET_VEC (RESET_VEC)
   ) u_pc (
      .clk  (clk),
      .rst  (rst),
      .pc_d (pc_d),
      .pc_q (pc_q)
   );

   assign fetch_addr = pc_q;
   assign instr      = fetch_word;
endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk #(
   parameter int unsigned       ADDR_W    = 32,
   parameter int unsigned       INSTR_W   = 32,
   parameter int unsigned       IMM_W     = 16,
   parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
   input logic               clk,
   input logic               rst,
   input logic               br_sel,
   input logic               eq_flag,
   input logic [IMM_W-1:0]   imm16,
   input logic [ADDR_W-1:0]  fetch_addr,
   input logic [INSTR_W-1:0] fetch_word,
   input logic [INSTR_W-1:0] instr
);
   localparam int unsigned EXT_W = ADDR_W - IMM_W - 2;

   AST_RESET_LOAD: assert property (@(posedge clk)
      rst |=> fetch_addr == RESET_VEC); // R1

   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
      !br_sel |=> fetch_addr == $past(fetch_addr) + ADDR_W'(4)); // R3

   AST_UNEQUAL_STEP: assert property (@(posedge clk) disable iff (rst)
      (br_sel && !eq_flag) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(4)); // R4

   AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (rst)
      (br_sel && eq_flag) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(4)
         + {{EXT_W{$past(imm16[IMM_W-1])}}, $past(imm16), 2'b00}); // R5

   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      fetch_addr[1:0] == 2'b00); // R8

   AST_WORD_PASS: assert property (@(posedge clk) disable iff (rst)
      instr == fetch_word); // R2
endmodule

bind fetch_unit fetch_unit_chk #(
   .ADDR_W    (ADDR_W),
   .INSTR_W   (INSTR_W),
   .IMM_W     (IMM_W),
   .RESET_VEC (RESET_VEC)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .br_sel     (br_sel),
   .eq_flag    (eq_flag),
   .imm16      (imm16),
   .fetch_addr (fetch_addr),
   .fetch_word (fetch_word),
   .instr      (instr)
);

// File: tb/fetch_unit_bench.sv
`timescale 1ns/100ps
module fetch_unit_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        br_sel = 1'b0;
   logic        eq_flag = 1'b0;
   logic [15:0] imm16 = '0;
   logic [31:0] fetch_addr;
   logic [31:0] fetch_word = '0;
   logic [31:0] instr;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [31:0] model_pc = '0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   fetch_unit u_fetch_unit (
      .clk        (clk),
      .rst        (rst),
      .br_sel     (br_sel),
      .eq_flag    (eq_flag),
      .imm16      (imm16),
      .fetch_addr (fetch_addr),
      .fetch_word (fetch_word),
      .instr      (instr)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: sets one cycle of inputs and pushes the expected next address
   task automatic step(input bit r, input bit b, input bit e, input logic [15:0] im,
                       input string tag);
      logic [31:0] nxt;
      @(negedge clk);
      rst = r; br_sel = b; eq_flag = e; imm16 = im;
      fetch_word = {im, ~im};
      #0.5;
      check("R2 instr pass-through", instr, {im, ~im});
      if (r)          nxt = 32'h0;
      else if (b && e) nxt = model_pc + 32'd4 + {{14{im[15]}}, im, 2'b00};
      else            nxt = model_pc + 32'd4;
      model_pc = nxt;
      exp_q.push_back(nxt);
      tag_q.push_back(tag);
   endtask

   // monitor: compares after each edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() != 0) begin
            check(tag_q.pop_front(), fetch_addr, exp_q.pop_front());
            check("R8 aligned", {30'd0, fetch_addr[1:0]}, 32'd0);
         end
      end
   end

   initial begin
      step(1, 1, 1, 16'h1234, "R1 reset");
      step(1, 0, 0, 16'h0000, "R1 reset hold");
      step(0, 1, 1, 16'h0005, "R5 forward taken");
      step(0, 0, 1, 16'h0003, "R3 no branch select");
      step(0, 0, 0, 16'h8000, "R3 no branch select");
      step(0, 1, 0, 16'h0040, "R4 unequal not taken");
      step(0, 1, 1, 16'hFFFD, "R6 backward");
      step(0, 1, 1, 16'h7FFF, "R9 max positive");
      step(0, 1, 1, 16'h8000, "R9 max negative");
      step(0, 1, 1, 16'h8000, "R7 wrap below zero");
      step(0, 0, 0, 16'h0000, "R3 seq after wrap");
      for (int i = 0; i < 3; i++) step(0, 1, 1, 16'h7FFF, "R7 wrap past top");
      step(0, 1, 1, 16'h0000, "R5 zero offset");
      for (int i = 0; i < 8; i++) step(0, i[0], i[1], 16'hA5A5, "R3 R4 mixed");
      step(1, 1, 1, 16'h7FFF, "R1 mid-run reset");
      step(0, 0, 0, 16'h0000, "R3 after reset");
      @(negedge clk);
      @(negedge clk);
      check("R7 queue drained", exp_q.size(), 32'd0);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule